// File: doc/BRIEF.md
# PLL Control and Status Register Block

This block is the register front end of a frequency-multiplying PLL that feeds several fractional synthesizer outputs. It stores the loop settings: a feedback multiplier and a reference pre-divider. It also holds an enable, a bypass control, a spare lock-control bit and one power-down bit for each synthesizer output. These settings go straight out to the analog loop and to the synthesizers. The block also reports the effective multiply and divide factors that set the nominal output rate.

The loop's lock detector is modelled as a timer. Enabling the PLL, or changing its multiplier or pre-divider while it runs, starts the timer. When the programmed number of reference cycles has passed, a read-only lock flag sets. In bypass, the bypass reference goes straight to every output and each synthesizer is forced into bypass. A build-time parameter selects the polarity of the bypass bit. Software reaches the two registers through a simple write strobe and a combinational read port, both using byte addresses.

Top module: `pllctl_regs`

## Requirements
- R1: After reset the control word reads 0, the power-down word reads all ones in its NOUT bits (every output powered down), and `locked` is 0.
- R2: The control word holds the multiplier in bits 31:16, the pre-divider in bits 15:8, enable in bit 3, bypass in bit 2 and lock-control in bit 0. Each field is writable, reads back unchanged and drives its output. Bits 6:4 and 1 read 0.
- R3: With BYPASS_INV=0, bit 2 set selects bypass. With BYPASS_INV=1, bit 2 clear selects bypass and bit 2 set selects normal operation.
- R4: While bypass is selected, every `synth_bypass` bit is 1 and both `eff_mult` and `eff_div` are 1. Otherwise every `synth_bypass` bit is 0.
- R5: Outside bypass, `eff_mult` equals the multiplier field and `eff_div` equals the pre-divider field, except that a field value of 0 is reported as 1.
- R6: The power-down word is at byte offset 4. Bit i set powers output i down (`synth_en[i]`=0) and bit i clear enables it. Bits at NOUT and above read 0.
- R7: A control write that changes enable from 0 to 1 clears `locked`. `locked` then becomes 1 on the D-th rising clock edge after the write edge, where D is `lock_delay`; a D of 0 acts as 1.
- R8: A control write that leaves enable at 1 and changes the multiplier or pre-divider restarts the R7 timing. A write with enable 1 and unchanged loop fields leaves `locked` as it was.
- R9: A control write with enable 0 makes `locked` 0 from the next clock edge.
- R10: Bit 7 of the control word is read-only. Writes to it are ignored, and a read returns the current `locked` value there.
- R11: Addresses other than 0 and 4 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; lock timing counts its edges |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| lock_delay | input | CNT_W | Lock settling time in reference cycles |
| rdata | output | 32 | Combinational read data for `addr` |
| mult_n | output | 16 | Raw multiplier field |
| prediv_p | output | 8 | Raw pre-divider field |
| pll_en | output | 1 | PLL enable |
| lock_ctl | output | 1 | Lock-control bit to the analog loop |
| locked | output | 1 | Lock flag |
| bypass_sel | output | 1 | 1 routes the bypass reference to the outputs |
| synth_en | output | NOUT | Per-output enable, inverse of power-down |
| synth_bypass | output | NOUT | Per-output forced bypass |
| eff_mult | output | 16 | Effective multiply factor |
| eff_div | output | 8 | Effective divide factor |

## Verification
Two copies of the block, one for each bypass polarity, share one bus. The same control word therefore shows that bit 2 selects bypass in one copy and normal operation in the other. The loop fields are tried with nonzero values, with zeros and with a single changed field, which separates the zero-as-one rule from the bypass override. Lock timing is exercised with a fresh enable, with a rewrite of identical settings and with a changed multiplier. These cases separate a start from a restart and from a non-event, counting edges from the write edge. A delay of zero and a write with enable cleared cover the edges of the timer.

// File: rtl/pllctl_pkg.sv
`timescale 1ns/1ps
package pllctl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned MULT_W   = 16;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned MULT_LSB = 16;
  localparam int unsigned DIV_LSB  = 8;
  localparam int unsigned LOCK_BIT = 7;
  localparam int unsigned EN_BIT   = 3;
  localparam int unsigned BYP_BIT  = 2;
  localparam int unsigned LC_BIT   = 0;
  localparam int unsigned CTRL_OFF = 0;
  localparam int unsigned PD_OFF   = 4;

  function automatic logic [MULT_W-1:0] nz_mult(input logic [MULT_W-1:0] v);
    return (v == '0) ? MULT_W'(1) : v;
  endfunction

  function automatic logic [DIV_W-1:0] nz_div(input logic [DIV_W-1:0] v);
    return (v == '0) ? DIV_W'(1) : v;
  endfunction

  function automatic logic bypass_of(input logic bit_val, input logic inv);
    return inv ? ~bit_val : bit_val;
  endfunction
endpackage

// File: rtl/pllctl_decode.sv
`timescale 1ns/1ps
module pllctl_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ctrl_hit,
  output logic              pd_hit
);
  import pllctl_pkg::*;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] PD_A   = ADDR_W'(PD_OFF);

  always_comb begin
    ctrl_hit = (addr == CTRL_A);
    pd_hit   = (addr == PD_A);
  end
endmodule

// File: rtl/pllctl_lock_timer.sv
`timescale 1ns/1ps
module pllctl_lock_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] delay,
  output logic             locked,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      busy   <= 1'b0;
      cnt_q  <= '0;
    end else if (abort) begin
      locked <= 1'b0;
      busy   <= 1'b0;
    end else if (start) begin
      locked <= 1'b0;
      busy   <= 1'b1;
      cnt_q  <= (delay == '0) ? CNT_W'(1) : delay;
    end else if (busy) begin
      if (last_tick) begin
        busy   <= 1'b0;
        locked <= 1'b1;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pllctl_pwrdn.sv
`timescale 1ns/1ps
module pllctl_pwrdn #(
  parameter int unsigned NOUT = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [NOUT-1:0] wbits,
  input  logic            bypass,
  output logic [NOUT-1:0] pd_q,
  output logic [NOUT-1:0] synth_en,
  output logic [NOUT-1:0] synth_bypass
);
  for (genvar i = 0; i < NOUT; i++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n)  pd_q[i] <= 1'b1;
      else if (wr) pd_q[i] <= wbits[i];
    end
    assign synth_en[i]     = ~pd_q[i];
    assign synth_bypass[i] = bypass;
  end
endmodule

// File: rtl/pllctl_regs.sv
`timescale 1ns/1ps
module pllctl_regs #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned NOUT       = 7,
  parameter int unsigned CNT_W      = 12,
  parameter bit          BYPASS_INV = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  lock_delay,
  output logic [31:0]       rdata,
  output logic [15:0]       mult_n,
  output logic [7:0]        prediv_p,
  output logic              pll_en,
  output logic              lock_ctl,
  output logic              locked,
  output logic              bypass_sel,
  output logic [NOUT-1:0]   synth_en,
  output logic [NOUT-1:0]   synth_bypass,
  output logic [15:0]       eff_mult,
  output logic [7:0]        eff_div
);
  import pllctl_pkg::*;
  localparam int unsigned PAD_W = DATA_W - NOUT;

  logic            ctrl_hit, pd_hit, ctrl_wr, pd_wr;
  logic            byp_q, new_en, loop_change, tmr_start, tmr_abort, tmr_busy;
  logic [NOUT-1:0] pd_q;
  logic [MULT_W-1:0] new_n;
  logic [DIV_W-1:0]  new_p;
  logic            unused_wbits;

  assign unused_wbits = ^{wdata[6:4], wdata[1], wdata[LOCK_BIT]};

  pllctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .ctrl_hit(ctrl_hit), .pd_hit(pd_hit)
  );

  assign ctrl_wr = wr_en & ctrl_hit;
  assign pd_wr   = wr_en & pd_hit;
  assign new_en  = wdata[EN_BIT];
  assign new_n   = wdata[MULT_LSB +: MULT_W];
  assign new_p   = wdata[DIV_LSB +: DIV_W];
  assign loop_change = (new_n != mult_n) || (new_p != prediv_p);
  assign tmr_start   = ctrl_wr & new_en & (~pll_en | loop_change);
  assign tmr_abort   = ctrl_wr & ~new_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_n   <= '0;
      prediv_p <= '0;
      pll_en   <= 1'b0;
      byp_q    <= 1'b0;
      lock_ctl <= 1'b0;
    end else if (ctrl_wr) begin
      mult_n   <= new_n;
      prediv_p <= new_p;
      pll_en   <= new_en;
      byp_q    <= wdata[BYP_BIT];
      lock_ctl <= wdata[LC_BIT];
    end
  end

  pllctl_lock_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .abort(tmr_abort),
    .delay(lock_delay), .locked(locked), .busy(tmr_busy)
  );

  assign bypass_sel = bypass_of(byp_q, BYPASS_INV);

  pllctl_pwrdn #(.NOUT(NOUT)) u_pd (
    .clk(clk), .rst_n(rst_n), .wr(pd_wr), .wbits(wdata[NOUT-1:0]),
    .bypass(bypass_sel), .pd_q(pd_q), .synth_en(synth_en),
    .synth_bypass(synth_bypass)
  );

  always_comb begin
    if (bypass_sel) begin
      eff_mult = MULT_W'(1);
      eff_div  = DIV_W'(1);
    end else begin
      eff_mult = nz_mult(mult_n);
      eff_div  = nz_div(prediv_p);
    end
  end

  always_comb begin
    rdata = '0;
    if (ctrl_hit) begin
      rdata[MULT_LSB +: MULT_W] = mult_n;
      rdata[DIV_LSB +: DIV_W]   = prediv_p;
      rdata[LOCK_BIT]           = locked;
      rdata[EN_BIT]             = pll_en;
      rdata[BYP_BIT]            = byp_q;
      rdata[LC_BIT]             = lock_ctl;
    end else if (pd_hit) begin
      rdata = {{PAD_W{1'b0}}, pd_q};
    end
  end
endmodule

// File: rtl/pllctl_regs_chk.sv
`timescale 1ns/1ps
module pllctl_regs_chk #(
  parameter int unsigned NOUT = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            ctrl_hit,
  input logic            pd_hit,
  input logic [31:0]     wdata,
  input logic [15:0]     mult_n,
  input logic [7:0]      prediv_p,
  input logic            pll_en,
  input logic            lock_ctl,
  input logic            locked,
  input logic            tmr_busy,
  input logic            bypass_sel,
  input logic [NOUT-1:0] synth_en,
  input logic [NOUT-1:0] synth_bypass,
  input logic [15:0]     eff_mult,
  input logic [7:0]      eff_div
);
  a_r7_lock_after_timer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(tmr_busy));
  a_r9_disabled_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |-> !locked);
  a_r9_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_hit && !wdata[3]) |=> !locked);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctrl_hit && wdata[3] && pll_en &&
     (wdata[31:16] != mult_n || wdata[15:8] != prediv_p)) |=> !locked);
  a_r4_bypass_forces: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_sel |-> (eff_mult == 16'd1 && eff_div == 8'd1 && &synth_bypass));
  a_r5_factors_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_mult != 16'd0) && (eff_div != 8'd0));
  a_r6_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && pd_hit) |=> $stable(synth_en));
  a_r11_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_hit && !pd_hit) |=>
      $stable({mult_n, prediv_p, pll_en, lock_ctl, bypass_sel}));
endmodule

bind pllctl_regs pllctl_regs_chk #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ctrl_hit(ctrl_hit),
  .pd_hit(pd_hit), .wdata(wdata), .mult_n(mult_n), .prediv_p(prediv_p),
  .pll_en(pll_en), .lock_ctl(lock_ctl), .locked(locked),
  .tmr_busy(tmr_busy), .bypass_sel(bypass_sel), .synth_en(synth_en),
  .synth_bypass(synth_bypass), .eff_mult(eff_mult), .eff_div(eff_div)
);

// File: tb/test_pllctl_regs.sv
`timescale 1ns/1ps
module test_pllctl_regs;
  localparam int unsigned NOUT = 7;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [11:0] lock_delay = 12'd5;
  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] rd_a, rd_b;
  logic [15:0] mn_a, mn_b, em_a, em_b;
  logic [7:0]  pp_a, pp_b, ed_a, ed_b;
  logic        en_a, en_b, lc_a, lc_b, lk_a, lk_b, by_a, by_b;
  logic [NOUT-1:0] se_a, se_b, sb_a, sb_b;

  always #10 clk = ~clk;

  pllctl_regs #(.BYPASS_INV(1'b0)) i_pllctl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lock_delay(lock_delay), .rdata(rd_a), .mult_n(mn_a), .prediv_p(pp_a),
    .pll_en(en_a), .lock_ctl(lc_a), .locked(lk_a), .bypass_sel(by_a),
    .synth_en(se_a), .synth_bypass(sb_a), .eff_mult(em_a), .eff_div(ed_a));

  pllctl_regs #(.BYPASS_INV(1'b1)) i_pllctl_regs_inv (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .lock_delay(lock_delay), .rdata(rd_b), .mult_n(mn_b), .prediv_p(pp_b),
    .pll_en(en_b), .lock_ctl(lc_b), .locked(lk_b), .bypass_sel(by_b),
    .synth_en(se_b), .synth_bypass(sb_b), .eff_mult(em_b), .eff_div(ed_b));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a);
    addr = a;
    #1;
  endtask

  task automatic t_reset();
    bus_rd(4'd0); chk("R1 ctrl", rd_a, 32'h0);
    bus_rd(4'd4); chk("R1 pd", rd_a, 32'h7F);
    chk("R1 locked", {31'd0, lk_a}, 32'd0);
    chk("R1 synth_en", {25'd0, se_a}, 32'd0);
    chk("R3 inv reset bypass", {31'd0, by_b}, 32'd1);
  endtask

  task automatic t_fields();
    bus_wr(4'd0, 32'h123456F7);
    bus_rd(4'd0);
    chk("R2 readback", rd_a, 32'h12345605);
    chk("R10 bit7 ignored", {31'd0, rd_a[7]}, 32'd0);
    chk("R2 mult_n", {16'd0, mn_a}, 32'h1234);
    chk("R2 prediv_p", {24'd0, pp_a}, 32'h56);
    chk("R2 lock_ctl", {31'd0, lc_a}, 32'd1);
    chk("R3 normal bypass", {31'd0, by_a}, 32'd1);
    chk("R3 inv not bypass", {31'd0, by_b}, 32'd0);
    chk("R4 eff in bypass", {em_a, ed_a, 8'd0}, {16'd1, 8'd1, 8'd0});
    chk("R4 synth bypass", {25'd0, sb_a}, 32'h7F);
    chk("R4 no synth bypass", {25'd0, sb_b}, 32'h0);
    chk("R5 eff inv", {em_b, ed_b, 8'd0}, {16'h1234, 8'h56, 8'd0});
  endtask

  task automatic t_zero();
    bus_wr(4'd0, 32'h0);
    chk("R5 zero fields", {em_a, ed_a, 8'd0}, {16'd1, 8'd1, 8'd0});
    bus_wr(4'd0, 32'h00030000);
    chk("R5 N=3 P=0", {em_a, ed_a, 8'd0}, {16'd3, 8'd1, 8'd0});
  endtask

  task automatic lock_wait(input string req, input int d);
    for (int i = 1; i <= d; i++) begin
      @(posedge clk); @(negedge clk);
      chk(req, {31'd0, lk_a}, {31'd0, (i == d)});
    end
  endtask

  task automatic t_lock();
    lock_delay = 12'd5;
    bus_wr(4'd0, 32'h00040208);
    chk("R7 cleared at start", {31'd0, lk_a}, 32'd0);
    lock_wait("R7 lock timing", 5);
    bus_rd(4'd0); chk("R10 live lock read", rd_a, 32'h00040288);
    bus_wr(4'd0, 32'h00040288);
    chk("R8 same settings keep lock", {31'd0, lk_a}, 32'd1);
    bus_wr(4'd0, 32'h00050208);
    chk("R8 restart clears", {31'd0, lk_a}, 32'd0);
    lock_wait("R8 restart timing", 5);
    bus_wr(4'd0, 32'h00050200);
    chk("R9 disable unlocks", {31'd0, lk_a}, 32'd0);
    repeat (7) @(posedge clk);
    @(negedge clk);
    chk("R9 stays unlocked", {31'd0, lk_a}, 32'd0);
  endtask

  task automatic t_delay0();
    lock_delay = 12'd0;
    bus_wr(4'd0, 32'h00020108);
    chk("R7 delay0 cleared", {31'd0, lk_a}, 32'd0);
    lock_wait("R7 delay0 acts as 1", 1);
    lock_delay = 12'd5;
  endtask

  task automatic t_pd();
    bus_wr(4'd4, 32'hFFFFFF2A);
    bus_rd(4'd4); chk("R6 pd readback", rd_a, 32'h2A);
    chk("R6 synth_en", {25'd0, se_a}, 32'h55);
  endtask

  task automatic t_unmapped();
    bus_wr(4'd8, 32'hFFFFFFFF);
    bus_rd(4'd8); chk("R11 unmapped read", rd_a, 32'h0);
    bus_rd(4'd0); chk("R11 ctrl unchanged", rd_a, 32'h00020188);
    bus_rd(4'd4); chk("R11 pd unchanged", rd_a, 32'h2A);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fields();
    t_zero();
    t_lock();
    t_delay0();
    t_pd();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule